// File: doc/BRIEF.md
# Interleaved Dual-Motor PWM Update Scheduler

This block runs two center-aligned PWM timers, one per motor, from one enable. The first timer is the master and the second counts only while the master runs, so both counters stay in lockstep. Each timer loads new compare values only at its own update event. An update event comes once every two PWM periods. The two update events are one period apart, so in each period exactly one motor owns the period. The per-motor control rate is therefore half the PWM rate.

Only the motor that owns the current period may fire the shared current-sampling converter. Each owned period has two trigger points, placed in the up-counting half or in a short grace span after it. Because ownership alternates, the trigger windows of the two motors never overlap and one converter serves both motors. Compare writes from the control side go into a shadow register first, so a duty change never tears a period.

Top module: `dual_pwm_sched`

## Requirements
- R1: While `rst_ni` is low, every output is 0 (`owner_o` reads motor 0).
- R2: Both timers start counting in the same cycle when `run_i` is high and stay in lockstep. Motor 1's first update strobe comes exactly one PWM period after motor 0's first.
- R3: A PWM period lasts 2*TOP cycles. Position p counts 0..2*TOP-1 from the first running cycle. The triangle level is p for p <= TOP and 2*TOP-p otherwise. `pwm_o[m]` is 1 exactly when the triangle level is below motor m's active compare value.
- R4: `upd_o[m]` pulses for one cycle at position 0 of each period that motor m owns. Motor 0 owns the first period after start and every second period after it. Motor 1 owns the periods in between.
- R5: While running, `owner_o` gives the index of the motor that owns the current period (0 or 1). When stopped, it reads 0.
- R6: In an owned period, `trig_o[m]` pulses at positions SAMPLE_A and SAMPLE_B. It never pulses in a period the motor does not own.
- R7: A trigger position later than TOP+GRACE-1 is moved to TOP+GRACE-1, so a trigger never falls outside the sampling window.
- R8: A write pulse on `cmp_wr_i[m]` stores `cmp_val_i[CMP_W*m +: CMP_W]` in motor m's shadow register. The active compare value takes the shadow value only at motor m's next update strobe, and it takes effect from the next position.
- R9: A write in the same cycle as that motor's update strobe is not used at that strobe. It takes effect at the strobe two periods later.
- R10: When `run_i` is low, both timers stop, the positions return to 0 and the outputs go to 0. A restart begins again with motor 0 owning the first period.
- R11: No cycle has triggers from both motors. No period has more than two triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Level enable for the master timer; the slave follows |
| cmp_wr_i | input | 2 | Per-motor write pulse into the shadow compare register |
| cmp_val_i | input | 2*CMP_W | Compare values; motor m in bits [CMP_W*m +: CMP_W] |
| pwm_o | output | 2 | Per-motor center-aligned PWM |
| upd_o | output | 2 | Per-motor update strobe (compare reload) |
| trig_o | output | 2 | Per-motor converter trigger pulse |
| owner_o | output | 1 | Motor that owns the current period |

## Verification
A compare write from the control side can land in the same cycle as that motor's reload strobe. The bench places a write on motor 1 in exactly the cycle where `upd_o[1]` is high. It sets the new value so that the PWM level at one mid-period position differs between the old and new compare. It then checks that the old duty still holds through that owned period and the next one, and that the new duty appears only after the following motor 1 strobe.

// File: rtl/dps_pkg.sv
package dps_pkg;

  localparam int unsigned NUM_MOTORS = 2;

  // triangle level of a center-aligned counter at a given period position
  function automatic int unsigned tri_level(int unsigned pos, int unsigned top);
    return (pos <= top) ? pos : (2 * top - pos);
  endfunction

  // move a requested trigger position into the legal sampling window
  function automatic int unsigned fit_sample(int unsigned want, int unsigned top,
                                             int unsigned grace);
    int unsigned lim;
    lim = top + grace - 1;
    return (want < lim) ? want : lim;
  endfunction

endpackage

// File: rtl/dps_timer.sv
module dps_timer #(
  parameter int unsigned TOP   = 16,
  parameter int unsigned PW    = 5,
  parameter bit          PHASE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          start_i,
  output logic          running_o,
  output logic          own_o,
  output logic          upd_o,
  output logic [PW-1:0] pos_o
);
  localparam int unsigned   PER  = 2 * TOP;
  localparam logic [PW-1:0] LAST = PW'(PER - 1);

  logic          run_q;
  logic [PW-1:0] pos_q;
  logic          rep_q;  // 0 = this timer owns the current period

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pos_q <= '0;
      rep_q <= PHASE;
    end else if (!run_i) begin
      run_q <= 1'b0;
      pos_q <= '0;
      rep_q <= PHASE;
    end else begin
      run_q <= 1'b1;
      if (run_q && start_i) begin
        if (pos_q == LAST) begin
          pos_q <= '0;
          rep_q <= ~rep_q;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign running_o = run_q;
  assign own_o     = run_q & ~rep_q;
  assign upd_o     = own_o & (pos_q == '0);
  assign pos_o     = pos_q;
endmodule

// File: rtl/dps_trig.sv
module dps_trig
  import dps_pkg::*;
#(
  parameter int unsigned TOP      = 16,
  parameter int unsigned GRACE    = 3,
  parameter int unsigned SAMPLE_A = 4,
  parameter int unsigned SAMPLE_B = 10,
  parameter int unsigned PW       = 5
) (
  input  logic          own_i,
  input  logic [PW-1:0] pos_i,
  output logic          trig_o
);
  localparam logic [PW-1:0] POS_A = PW'(fit_sample(SAMPLE_A, TOP, GRACE));
  localparam logic [PW-1:0] POS_B = PW'(fit_sample(SAMPLE_B, TOP, GRACE));

  assign trig_o = own_i && ((pos_i == POS_A) || (pos_i == POS_B));
endmodule

// File: rtl/dps_cmp.sv
module dps_cmp
  import dps_pkg::*;
#(
  parameter int unsigned TOP = 16,
  parameter int unsigned PW  = 5,
  parameter int unsigned CW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [CW-1:0] val_i,
  input  logic          upd_i,
  input  logic          run_i,
  input  logic [PW-1:0] pos_i,
  output logic [CW-1:0] act_o,
  output logic          pwm_o
);
  logic [CW-1:0] shadow_q;
  logic [CW-1:0] act_q;
  logic [31:0]   level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      act_q    <= '0;
    end else begin
      if (upd_i) act_q    <= shadow_q;  // old shadow wins over a same-cycle write
      if (wr_i)  shadow_q <= val_i;
    end
  end

  assign level = tri_level(32'(pos_i), TOP);
  assign pwm_o = run_i && (level < 32'(act_q));
  assign act_o = act_q;
endmodule

// File: rtl/dual_pwm_sched.sv
module dual_pwm_sched
  import dps_pkg::*;
#(
  parameter int unsigned TOP      = 16,
  parameter int unsigned GRACE    = 3,
  parameter int unsigned SAMPLE_A = 4,
  parameter int unsigned SAMPLE_B = 10,
  parameter int unsigned CMP_W    = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic [NUM_MOTORS-1:0]       cmp_wr_i,
  input  logic [NUM_MOTORS*CMP_W-1:0] cmp_val_i,
  output logic [NUM_MOTORS-1:0]       pwm_o,
  output logic [NUM_MOTORS-1:0]       upd_o,
  output logic [NUM_MOTORS-1:0]       trig_o,
  output logic                        owner_o
);
  localparam int unsigned PER = 2 * TOP;
  localparam int unsigned PW  = $clog2(PER);

  // named internal events, also watched by the bound checker
  logic [NUM_MOTORS-1:0]           run_w;
  logic [NUM_MOTORS-1:0]           own_w;
  logic [NUM_MOTORS-1:0][PW-1:0]   pos_w;
  logic [NUM_MOTORS-1:0][CMP_W-1:0] act_w;

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_motor
    logic start_w;
    if (m == 0) begin : g_master
      assign start_w = 1'b1;
    end else begin : g_slave
      assign start_w = run_w[0];
    end

    dps_timer #(.TOP(TOP), .PW(PW), .PHASE(m[0])) u_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_i),
      .start_i  (start_w),
      .running_o(run_w[m]),
      .own_o    (own_w[m]),
      .upd_o    (upd_o[m]),
      .pos_o    (pos_w[m])
    );

    dps_trig #(.TOP(TOP), .GRACE(GRACE), .SAMPLE_A(SAMPLE_A),
               .SAMPLE_B(SAMPLE_B), .PW(PW)) u_trig (
      .own_i (own_w[m]),
      .pos_i (pos_w[m]),
      .trig_o(trig_o[m])
    );

    dps_cmp #(.TOP(TOP), .PW(PW), .CW(CMP_W)) u_cmp (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (cmp_wr_i[m]),
      .val_i (cmp_val_i[CMP_W*m +: CMP_W]),
      .upd_i (upd_o[m]),
      .run_i (run_w[m]),
      .pos_i (pos_w[m]),
      .act_o (act_w[m]),
      .pwm_o (pwm_o[m])
    );
  end

  assign owner_o = run_w[0] & ~own_w[0];
endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter int unsigned PW = 5,
  parameter int unsigned CW = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          run_w,
  input logic [1:0][PW-1:0]  pos_w,
  input logic [1:0][CW-1:0]  act_w,
  input logic [1:0]          upd_o,
  input logic [1:0]          trig_o,
  input logic                owner_o
);
  logic [1:0] cnt_q;
  logic [2:0] per_cnt;

  assign per_cnt = ((pos_w[0] == '0) ? 3'd0 : {1'b0, cnt_q})
                 + 3'(trig_o[0]) + 3'(trig_o[1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= (per_cnt > 3'd3) ? 2'd3 : per_cnt[1:0];
  end

  assert_lockstep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w[0] == run_w[1]) && (pos_w[0] == pos_w[1]));

  assert_upd_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_o));

  assert_owner_flip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_w[0] && $past(run_w[0]) && pos_w[0] == '0) |-> (owner_o != $past(owner_o)));

  assert_trig0_owner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o[0] |-> !owner_o);

  assert_trig1_owner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o[1] |-> owner_o);

  assert_act0_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(act_w[0]) || $past(upd_o[0])));

  assert_act1_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($stable(act_w[1]) || $past(upd_o[1])));

  assert_no_dual_trig_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trig_o));

  assert_two_per_period_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_cnt <= 3'd2);
endmodule

bind dual_pwm_sched dps_chk #(.PW(PW), .CW(CMP_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_w  (run_w),
  .pos_w  (pos_w),
  .act_w  (act_w),
  .upd_o  (upd_o),
  .trig_o (trig_o),
  .owner_o(owner_o)
);

// File: tb/dual_pwm_sched_test.sv
module dual_pwm_sched_test;
  localparam int TOP = 16;
  localparam int PER = 2 * TOP;
  localparam int SA  = 4;
  localparam int SB  = 10;
  localparam int SB_FIT = 18;  // 40 moved to TOP+GRACE-1

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [1:0]  cmp_wr = 2'b00;
  logic [15:0] cmp_val = '0;
  logic [1:0]  pwm, upd, trig, pwm2, upd2, trig2;
  logic        owner, owner2;

  int checks = 0;
  int errors = 0;
  // bench model
  bit mrun = 0;
  int t = 0;
  int act[2] = '{0, 0};
  int shad[2] = '{0, 0};

  always #5 clk = ~clk;

  dual_pwm_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_wr_i(cmp_wr),
    .cmp_val_i(cmp_val), .pwm_o(pwm), .upd_o(upd), .trig_o(trig), .owner_o(owner));

  dual_pwm_sched #(.SAMPLE_B(40)) uut_sat (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cmp_wr_i(cmp_wr),
    .cmp_val_i(cmp_val), .pwm_o(pwm2), .upd_o(upd2), .trig_o(trig2), .owner_o(owner2));

  function automatic int tri_b(int p);
    if (p > TOP) return PER - p;
    return p;
  endfunction

  task automatic chk(int got, int exp, string tag, string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic look();
    int pos = t % PER;
    int own = (t / PER) % 2;
    for (int m = 0; m < 2; m++) begin
      chk(int'(upd[m]), int'(mrun && pos == 0 && own == m), "R4", $sformatf("upd%0d t=%0d", m, t));
      chk(int'(trig[m]), int'(mrun && own == m && (pos == SA || pos == SB)), "R6",
          $sformatf("trig%0d t=%0d", m, t));
      chk(int'(trig2[m]), int'(mrun && own == m && (pos == SA || pos == SB_FIT)), "R7",
          $sformatf("fitted trig%0d t=%0d", m, t));
      chk(int'(pwm[m]), int'(mrun && tri_b(pos) < act[m]), "R3 R8",
          $sformatf("pwm%0d t=%0d", m, t));
    end
    chk(int'(owner), int'(mrun && own == 1), "R5", $sformatf("owner t=%0d", t));
    chk(int'(trig != 2'b11), 1, "R11", "both triggers");
  endtask

  task automatic step();
    int pos = t % PER;
    int own = (t / PER) % 2;
    look();
    if (mrun && pos == 0) act[own] = shad[own];
    for (int m = 0; m < 2; m++) if (cmp_wr[m]) shad[m] = int'(cmp_val[8*m +: 8]);
    if (!run) begin mrun = 0; t = 0; end
    else if (!mrun) begin mrun = 1; t = 0; end
    else t++;
    @(posedge clk);
    @(negedge clk);
    cmp_wr = 2'b00;
  endtask

  task automatic go_to(int p, int o);
    while (!(mrun && (t % PER) == p && ((t / PER) % 2) == o)) step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(int'(pwm), 0, "R1", "pwm in reset");
    chk(int'(upd), 0, "R1", "upd in reset");
    chk(int'(trig), 0, "R1", "trig in reset");
    chk(int'(owner), 0, "R1", "owner in reset");
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_schedule();
    int n0 = -1;
    int n1 = -1;
    cmp_val = {8'd9, 8'd5};
    cmp_wr = 2'b11;
    step();
    run = 1'b1;
    for (int i = 0; i < 4 * PER + 2; i++) begin
      if (upd[0] && n0 < 0) n0 = i;
      if (upd[1] && n1 < 0) n1 = i;
      step();
    end
    chk(n1 - n0, PER, "R2", "gap between first strobes");
  endtask

  task automatic t_shadow();
    go_to(7, 1);
    cmp_val[7:0] = 8'd12;
    cmp_wr = 2'b01;
    step();
    go_to(8, 1);
    chk(int'(pwm[0]), 0, "R8", "motor0 duty before its reload");
    go_to(8, 0);
    chk(int'(pwm[0]), 1, "R8", "motor0 duty after its reload");
  endtask

  task automatic t_collide();
    go_to(0, 1);
    chk(int'(upd[1]), 1, "R9", "strobe present at write");
    cmp_val[15:8] = 8'd3;
    cmp_wr = 2'b10;
    step();
    go_to(8, 1);
    chk(int'(pwm[1]), 1, "R9", "old duty kept this period");
    step();
    go_to(8, 1);
    chk(int'(pwm[1]), 0, "R9", "new duty after following strobe");
  endtask

  task automatic t_stop();
    go_to(20, 0);
    run = 1'b0;
    step();
    chk(int'(pwm), 0, "R10", "pwm stopped");
    chk(int'(upd | trig), 0, "R10", "events stopped");
    chk(int'(owner), 0, "R10", "owner stopped");
    step();
    step();
    run = 1'b1;
    step();
    chk(int'(upd), 1, "R10", "motor0 strobe first after restart");
    chk(int'(owner), 0, "R10", "motor0 owns first period");
    for (int i = 0; i < 2 * PER; i++) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_schedule();
    t_shadow();
    t_collide();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule